// File: doc/BRIEF.md
# Associative Rename Register File

This block is a single physical register file that performs register renaming and also acts as the reorder buffer. Each entry records four things: the architectural register it stands for, a newest-copy flag, a data word, and a flag that says whether that data has been produced. A source operand is found with one content-addressable match. The requested register number is compared against every entry that is allocated and marked newest. There is no separate map table.

Destinations are allocated in program order at a circular tail, and results are retired in order at the head. Allocating register R moves the newest-copy flag from the older entry for R to the new entry. This removes write-after-read and write-after-write hazards. Retirement copies an entry's value into the committed architectural values and frees the entry. An entry marked speculative is held at the head until the branch it depends on is resolved. A flush discards every uncommitted entry, so a lookup then returns the committed state again, which gives precise interrupts.

Top module: `assoc_rename_rf`

## Requirements
- R1: After reset the file is empty and `alloc_ready` is 1. A lookup of register r returns `src_ready`=1 and `src_data`=r, because committed register r resets to the value r.
- R2: When the newest entry for a register has no value yet, a lookup returns `src_ready`=0 and `src_tag` equal to that entry's index.
- R3: A writeback by index sets the entry's value and its value-valid flag in one edge. From the next cycle, a lookup that matches the entry returns `src_ready`=1 and the written data.
- R4: A second allocation of the same register takes over the newest-copy flag, so lookups report the newer entry.
- R5: Entries are handed out in order. `alloc_idx` shows the index the next allocation receives, and it counts up from 0 and wraps after PHYS_REGS-1.
- R6: With PHYS_REGS entries outstanding, `alloc_ready` is 0 and an allocation request changes nothing.
- R7: While `commit_en` is 1, the head entry retires once its value is present. `commit_valid`, `commit_arch` and `commit_data` report it in the same cycle. Retirement is strictly in allocation order, and the retired value becomes the committed value that later lookups return.
- R8: An entry allocated with `alloc_spec`=1 does not retire until a `spec_resolve` pulse has been seen. It may retire in the cycle after that pulse.
- R9: A `flush` discards all uncommitted entries. Lookups then return committed values, and the next allocation index equals the oldest discarded index.
- R10: A lookup in the same cycle as an allocation of the same register sees the mapping from before that allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a destination entry |
| alloc_arch | input | AW | Architectural register being written |
| alloc_spec | input | 1 | New entry lies under an unresolved branch |
| alloc_ready | output | 1 | A free entry exists |
| alloc_idx | output | PW | Index the next allocation receives |
| src_arch | input | AW | Register looked up |
| src_ready | output | 1 | `src_data` holds the operand |
| src_data | output | DATA_W | Operand value |
| src_tag | output | PW | Entry that will produce the operand |
| wb_valid | input | 1 | Write a result |
| wb_idx | input | PW | Entry receiving the result |
| wb_data | input | DATA_W | Result value |
| commit_en | input | 1 | Permit retirement this cycle |
| commit_valid | output | 1 | Head entry retires this cycle |
| commit_arch | output | AW | Register of the retiring entry |
| commit_data | output | DATA_W | Value of the retiring entry |
| spec_resolve | input | 1 | Pending branch was predicted correctly |
| flush | input | 1 | Discard all uncommitted entries |

## Verification
The hardest state to reach is a wrapped, full file in which two generations of every register are outstanding. In that state only the younger entries hold values, and retirement has to stall at an unwritten head. The stimulus allocates every architectural register twice, which fills all entries, and writes back only the younger generation with retirement enabled. It then writes the older generation, drains all entries, and checks the retirement order and the committed values. Speculative hold and flush recovery are each tested against a file that has already wrapped.

// File: rtl/assoc_rename_rf.sv
module assoc_rename_rf #(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  parameter int DATA_W    = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          alloc_valid,
  input  logic [$clog2(ARCH_REGS)-1:0]  alloc_arch,
  input  logic                          alloc_spec,
  output logic                          alloc_ready,
  output logic [$clog2(PHYS_REGS)-1:0]  alloc_idx,
  input  logic [$clog2(ARCH_REGS)-1:0]  src_arch,
  output logic                          src_ready,
  output logic [DATA_W-1:0]             src_data,
  output logic [$clog2(PHYS_REGS)-1:0]  src_tag,
  input  logic                          wb_valid,
  input  logic [$clog2(PHYS_REGS)-1:0]  wb_idx,
  input  logic [DATA_W-1:0]             wb_data,
  input  logic                          commit_en,
  output logic                          commit_valid,
  output logic [$clog2(ARCH_REGS)-1:0]  commit_arch,
  output logic [DATA_W-1:0]             commit_data,
  input  logic                          spec_resolve,
  input  logic                          flush
);
  localparam int AW = $clog2(ARCH_REGS);
  localparam int PW = $clog2(PHYS_REGS);
  localparam int CW = PW + 1;

  logic [AW-1:0]     ent_arch [PHYS_REGS];
  logic [DATA_W-1:0] ent_val  [PHYS_REGS];
  logic [DATA_W-1:0] arch_val [ARCH_REGS];
  logic [PHYS_REGS-1:0] busy, newest, vvalid, spec;
  logic [PHYS_REGS-1:0] match;
  logic [PW-1:0] head, tail, hit_idx;
  logic [CW-1:0] count;
  logic hit, alloc_fire, commit_fire;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(PHYS_REGS - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < PHYS_REGS; g++) begin : g_cam
    assign match[g] = busy[g] && newest[g] && (ent_arch[g] == src_arch);
  end

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < PHYS_REGS; i++)
      if (match[i]) begin
        hit = 1'b1;
        hit_idx = i[PW-1:0];
      end
  end

  assign src_ready = !hit || vvalid[hit_idx];
  assign src_data  = hit ? ent_val[hit_idx] : arch_val[src_arch];
  assign src_tag   = hit_idx;

  assign alloc_ready  = (count != CW'(PHYS_REGS));
  assign alloc_idx    = tail;
  assign alloc_fire   = alloc_valid && alloc_ready && !flush;
  assign commit_fire  = commit_en && !flush && (count != '0) && vvalid[head] && !spec[head];
  assign commit_valid = commit_fire;
  assign commit_arch  = ent_arch[head];
  assign commit_data  = ent_val[head];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0; newest <= '0; vvalid <= '0; spec <= '0;
      head <= '0; tail <= '0; count <= '0;
      for (int i = 0; i < PHYS_REGS; i++) begin
        ent_arch[i] <= '0;
        ent_val[i]  <= '0;
      end
      for (int r = 0; r < ARCH_REGS; r++) arch_val[r] <= DATA_W'(r);
    end else if (flush) begin
      busy <= '0; newest <= '0; vvalid <= '0; spec <= '0;
      tail <= head;
      count <= '0;
    end else begin
      if (spec_resolve) spec <= '0;
      if (wb_valid && busy[wb_idx]) begin
        ent_val[wb_idx] <= wb_data;
        vvalid[wb_idx]  <= 1'b1;
      end
      if (commit_fire) begin
        busy[head]   <= 1'b0;
        newest[head] <= 1'b0;
        arch_val[ent_arch[head]] <= ent_val[head];
        head <= bump(head);
      end
      if (alloc_fire) begin
        for (int j = 0; j < PHYS_REGS; j++)
          if (busy[j] && ent_arch[j] == alloc_arch) newest[j] <= 1'b0;
        busy[tail]     <= 1'b1;
        newest[tail]   <= 1'b1;
        vvalid[tail]   <= 1'b0;
        spec[tail]     <= alloc_spec;
        ent_arch[tail] <= alloc_arch;
        tail <= bump(tail);
      end
      count <= count + CW'(alloc_fire) - CW'(commit_fire);
    end
  end

  AST_MATCH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match)); // R2
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) count <= CW'(PHYS_REGS)); // R6
  AST_ALLOC_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> (busy[$past(tail)] && newest[$past(tail)])); // R4
  AST_SPEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_en && busy[head] && spec[head] && !spec_resolve && !flush) |=> (head == $past(head))); // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0 && busy == '0)); // R9
endmodule

// File: tb/assoc_rename_rf_tb.sv
module assoc_rename_rf_tb;
  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, alloc_spec = 0, wb_valid = 0, commit_en = 0, spec_resolve = 0, flush = 0;
  logic [2:0] alloc_arch = 0, src_arch = 0, commit_arch;
  logic [3:0] alloc_idx, src_tag, wb_idx = 0;
  logic [15:0] src_data, wb_data = 0, commit_data;
  logic alloc_ready, src_ready, commit_valid;
  int vecs = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assoc_rename_rf u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic look(input int r, input bit rdy, input int val, input string req);
    src_arch = 3'(r); #1;
    chk(src_ready == rdy, req, int'(src_ready), int'(rdy));
    if (rdy) chk(src_data == 16'(val), req, int'(src_data), val);
    else     chk(src_tag == 4'(val), req, int'(src_tag), val);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(alloc_ready == 1, "R1", int'(alloc_ready), 1);
    for (int r = 0; r < 8; r++) look(r, 1, r, "R1");

    for (int r = 0; r < 8; r++) begin
      alloc_valid = 1; alloc_arch = 3'(r);
      look(r, 1, r, "R10");
      chk(alloc_idx == 4'(r), "R5", int'(alloc_idx), r);
      step();
    end
    alloc_valid = 0;
    for (int r = 0; r < 8; r++) look(r, 0, r, "R2");

    for (int r = 0; r < 8; r++) begin
      alloc_valid = 1; alloc_arch = 3'(r);
      look(r, 0, r, "R10");
      chk(alloc_idx == 4'(8 + r), "R5", int'(alloc_idx), 8 + r);
      step();
    end
    alloc_valid = 0; #1;
    chk(alloc_ready == 0, "R6", int'(alloc_ready), 0);
    chk(alloc_idx == 0, "R5", int'(alloc_idx), 0);
    alloc_valid = 1; alloc_arch = 0; step(); alloc_valid = 0;
    for (int r = 0; r < 8; r++) look(r, 0, 8 + r, "R4");
    look(0, 0, 8, "R6");

    commit_en = 1;
    for (int r = 0; r < 8; r++) begin
      wb_valid = 1; wb_idx = 4'(8 + r); wb_data = 16'(256 + r); #1;
      chk(commit_valid == 0, "R7", int'(commit_valid), 0);
      step();
    end
    wb_valid = 0; #1;
    chk(commit_valid == 0, "R7", int'(commit_valid), 0);
    commit_en = 0;
    for (int r = 0; r < 8; r++) look(r, 1, 256 + r, "R3");

    for (int r = 0; r < 8; r++) begin
      wb_valid = 1; wb_idx = 4'(r); wb_data = 16'(80 + r); step();
    end
    wb_valid = 0; commit_en = 1;
    for (int k = 0; k < 16; k++) begin
      #1;
      chk(commit_valid == 1, "R7", int'(commit_valid), 1);
      chk(commit_arch == 3'(k % 8), "R7", int'(commit_arch), k % 8);
      chk(commit_data == 16'(k < 8 ? 80 + k : 248 + k), "R7", int'(commit_data), k < 8 ? 80 + k : 248 + k);
      step();
    end
    #1;
    chk(commit_valid == 0, "R7", int'(commit_valid), 0);
    commit_en = 0;
    chk(alloc_ready == 1, "R7", int'(alloc_ready), 1);
    for (int r = 0; r < 8; r++) look(r, 1, 256 + r, "R7");

    alloc_valid = 1; alloc_arch = 1; alloc_spec = 1; step();
    alloc_valid = 0; alloc_spec = 0;
    wb_valid = 1; wb_idx = 0; wb_data = 16'hAA; step(); wb_valid = 0;
    commit_en = 1;
    for (int k = 0; k < 3; k++) begin
      #1; chk(commit_valid == 0, "R8", int'(commit_valid), 0); step();
    end
    spec_resolve = 1; #1;
    chk(commit_valid == 0, "R8", int'(commit_valid), 0);
    step(); spec_resolve = 0; #1;
    chk(commit_valid == 1 && commit_data == 16'hAA && commit_arch == 1, "R8", int'(commit_data), 16'hAA);
    step(); commit_en = 0;
    look(1, 1, 16'hAA, "R8");

    alloc_valid = 1; alloc_arch = 2; step();
    step(); alloc_valid = 0;
    wb_valid = 1; wb_idx = 2; wb_data = 16'h77; step(); wb_valid = 0;
    look(2, 1, 16'h77, "R3");
    flush = 1; step(); flush = 0;
    look(2, 1, 258, "R9");
    look(1, 1, 16'hAA, "R9");
    chk(alloc_idx == 1, "R9", int'(alloc_idx), 1);
    chk(alloc_ready == 1, "R9", int'(alloc_ready), 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vecs++; bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule